// File: doc/BRIEF.md
# Byte ALU with Masked Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each accepted operation takes an operation code and two byte operands, or for the two word operations a register pair and a small unsigned immediate. It returns a result together with a mask of the status flags that the operation changes. The status flags are the carry C, zero Z, negative N, two's-complement overflow V, signed sign S and half-carry H. They live in a flag register inside the block. Carry-consuming operations read carry from that register, and every completed operation writes only the flags in its mask.

Operations arrive on a valid/ready input and leave on a valid/ready output that holds one result. A new operation is accepted only when the output slot is empty or is being drained in the same cycle. While the output is held with `out_ready` low, the block accepts nothing and the result does not move. A byte operation presents its result in the cycle after acceptance. A word operation holds the input for one extra cycle: the low byte is computed on the first pass and the high byte on the second, and both passes use the same adder. The operation codes are the package enumeration `alu_op_e`. For byte operations `in_b` is the second operand (register or immediate). For word operations `in_a` is the low byte, `in_b` the high byte and `in_k` the immediate.

Top module: `alu8_core`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and all flags are 0. The flag bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, in both `flags` and `out_flag_we`.
- R2: Add and add-with-carry return a+b (+C for the carry form) and write C, Z, N, V, S and H. H is the carry out of bit 3 and V is signed overflow.
- R3: Subtract, subtract-with-carry and negate return a-b (-C), or 0-a for negate, and write all six flags. C is the borrow out of bit 7 and H is the borrow into bit 4.
- R4: Compare and compare-with-carry set all six flags as the matching subtraction does, and drive `out_wr` to 0. Every other operation drives `out_wr` to 1.
- R5: AND, OR and XOR write only Z, N, V and S. They force V to 0 and leave C and H unchanged.
- R6: Complement returns 0xFF-a, sets C to 1 and V to 0, and writes Z, N and S. H is unchanged.
- R7: Increment and decrement write only Z, N, V and S. V is set on 0x7F→0x80 and on 0x80→0x7F. C and H are unchanged.
- R8: Logical left shift fills bit 0 with 0, logical right shift fills bit 7 with 0, and arithmetic right shift keeps bit 7. C receives the bit shifted out and V=N^C. H is unchanged.
- R9: Rotate left moves C into bit 0 and bit 7 into C. Rotate right moves C into bit 7 and bit 0 into C. V=N^C.
- R10: Nibble swap and load-all-ones change no flag and report a mask of 0.
- R11: Word add and word subtract return {hi,lo}±k on `out_res_hi`/`out_res`. They write C, Z, N, V and S from the 16-bit result, leave H unchanged, and deliver the result two cycles after acceptance.
- R12: Whenever N or V is written, S is written as N^V.
- R13: A byte result is valid in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and the result stays stable.
- R14: Flags change only in the bit positions set in `out_flag_we` of the result loaded at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when valid |
| in_op | input | 5 | Operation code (`alu_op_e`) |
| in_a | input | 8 | First operand, or low byte of the pair |
| in_b | input | 8 | Second operand, or high byte of the pair |
| in_k | input | 6 | Word immediate |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 8 | Result, or low byte of the word result |
| out_res_hi | output | 8 | High byte of the word result, 0 otherwise |
| out_wr | output | 1 | Result is meant to be written back |
| out_flag_we | output | 6 | Flags written by this result |
| flags | output | 6 | Flag register |

## Verification
Two things can fall on the same clock edge. One operation's flag write can land on the edge where the next operation reads carry. A held result can drain on the edge where a new operation is accepted. The first case is provoked by offering a subtraction that borrows, then a zero-operand add-with-carry on the very next cycle. The add-with-carry must return 1, which shows that it read the carry written one edge earlier. The second case is provoked by stalling the output with an operation already waiting. When `out_ready` rises, the next sample must show the waiting operation's result and no lost or duplicated value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 6;
  localparam int FB_C = 0;
  localparam int FB_Z = 1;
  localparam int FB_N = 2;
  localparam int FB_V = 3;
  localparam int FB_S = 4;
  localparam int FB_H = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
    OP_AND, OP_OR, OP_XOR, OP_COM, OP_NEG, OP_INC, OP_DEC,
    OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR, OP_NSWAP, OP_ONES,
    OP_WADD, OP_WSUB
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         cout,
  output logic         hc,
  output logic         ovf
);
  localparam int HW = W / 2;

  logic [W:0]  full;
  logic [HW:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      half = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      half = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
    end
  end

  assign r    = full[W-1:0];
  assign cout = full[W];
  assign hc   = half[HW];

  // signed overflow from operand and result signs
  always_comb begin
    if (sub) ovf = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    else     ovf = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary import alu8_pkg::*; #(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         cout
);
  localparam int HW = W / 2;

  always_comb begin
    r    = '0;
    cout = 1'b0;
    case (op)
      OP_AND:   r = a & b;
      OP_OR:    r = a | b;
      OP_XOR:   r = a ^ b;
      OP_COM:   begin r = ~a; cout = 1'b1; end
      OP_SHL:   begin r = {a[W-2:0], 1'b0};   cout = a[W-1]; end
      OP_SHR:   begin r = {1'b0, a[W-1:1]};   cout = a[0];   end
      OP_SAR:   begin r = {a[W-1], a[W-1:1]}; cout = a[0];   end
      OP_RCL:   begin r = {a[W-2:0], cin};    cout = a[W-1]; end
      OP_RCR:   begin r = {cin, a[W-1:1]};    cout = a[0];   end
      OP_NSWAP: r = {a[HW-1:0], a[W-1:HW]};
      OP_ONES:  r = '1;
      default:  r = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [FW-1:0] mask,
  input  logic [FW-1:0] nxt,
  output logic [FW-1:0] q
);
  for (genvar i = 0; i < FW; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               bit_q <= 1'b0;
      else if (upd && mask[i])  bit_q <= nxt[i];
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core import alu8_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [OP_W-1:0]      in_op,
  input  logic [DATA_W-1:0]    in_a,
  input  logic [DATA_W-1:0]    in_b,
  input  logic [IMM_W-1:0]     in_k,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_res,
  output logic [DATA_W-1:0]    out_res_hi,
  output logic                 out_wr,
  output logic [FLAG_W-1:0]    out_flag_we,
  output logic [FLAG_W-1:0]    flags
);
  localparam logic [FLAG_W-1:0] M_ALL   = '1;
  localparam logic [FLAG_W-1:0] M_LOGIC = FLAG_W'((1 << FB_Z) | (1 << FB_N) | (1 << FB_V) | (1 << FB_S));
  localparam logic [FLAG_W-1:0] M_SHIFT = M_LOGIC | FLAG_W'(1 << FB_C);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

  alu_op_e op_e;
  assign op_e = alu_op_e'(in_op);

  logic is_word, accept, load;
  logic busy_q, wsub_q, c1_q;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic ov_q, wr_q;
  logic [DATA_W-1:0] res_q, res_hi_q;
  logic [FLAG_W-1:0] we_q, flags_q;

  assign is_word  = (op_e == OP_WADD) || (op_e == OP_WSUB);
  assign in_ready = !busy_q && (!ov_q || out_ready);
  assign accept   = in_valid && in_ready;
  assign load     = (accept && !is_word) || busy_q;

  // shared adder operand steering
  logic [DATA_W-1:0] as_a, as_b, as_r;
  logic as_cin, as_sub, as_c, as_h, as_v;

  always_comb begin
    as_a   = in_a;
    as_b   = in_b;
    as_cin = 1'b0;
    as_sub = 1'b0;
    if (busy_q) begin
      as_a   = hi_q;
      as_b   = '0;
      as_cin = c1_q;
      as_sub = wsub_q;
    end else begin
      case (op_e)
        OP_ADC:         as_cin = flags_q[FB_C];
        OP_SUB, OP_CMP: as_sub = 1'b1;
        OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = flags_q[FB_C]; end
        OP_NEG:         begin as_a = '0; as_b = in_a; as_sub = 1'b1; end
        OP_INC:         as_b = ONE;
        OP_DEC:         begin as_b = ONE; as_sub = 1'b1; end
        OP_WADD:        as_b = {{(DATA_W-IMM_W){1'b0}}, in_k};
        OP_WSUB:        begin as_b = {{(DATA_W-IMM_W){1'b0}}, in_k}; as_sub = 1'b1; end
        default:        ;
      endcase
    end
  end

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
    .r(as_r), .cout(as_c), .hc(as_h), .ovf(as_v)
  );

  logic [DATA_W-1:0] un_r;
  logic un_c;

  alu8_unary #(.W(DATA_W)) u_unary (
    .op(op_e), .a(in_a), .b(in_b), .cin(flags_q[FB_C]),
    .r(un_r), .cout(un_c)
  );

  // result and flag composition
  logic [DATA_W-1:0] nres, nres_hi;
  logic [FLAG_W-1:0] nflag, nmask;
  logic nwr, fc, fh, fv, fn, fz;

  always_comb begin
    nres    = '0;
    nres_hi = '0;
    nmask   = '0;
    nwr     = 1'b1;
    fc      = 1'b0;
    fh      = 1'b0;
    fv      = 1'b0;
    if (busy_q) begin
      nres    = lo_q;
      nres_hi = as_r;
      fc      = as_c;
      fv      = as_v;
      nmask   = M_SHIFT;
    end else begin
      case (op_e)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
          nres  = as_r;
          fc    = as_c;
          fh    = as_h;
          fv    = as_v;
          nmask = M_ALL;
          nwr   = !(op_e == OP_CMP || op_e == OP_CPC);
        end
        OP_INC, OP_DEC: begin
          nres  = as_r;
          fv    = as_v;
          nmask = M_LOGIC;
        end
        OP_AND, OP_OR, OP_XOR: begin
          nres  = un_r;
          nmask = M_LOGIC;
        end
        OP_COM: begin
          nres  = un_r;
          fc    = un_c;
          nmask = M_SHIFT;
        end
        OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR: begin
          nres  = un_r;
          fc    = un_c;
          fv    = un_r[DATA_W-1] ^ un_c;
          nmask = M_SHIFT;
        end
        OP_NSWAP, OP_ONES: nres = un_r;
        default: nwr = 1'b0;
      endcase
    end
    fn = busy_q ? nres_hi[DATA_W-1] : nres[DATA_W-1];
    fz = (nres == '0) && (nres_hi == '0);
    nflag = '0;
    nflag[FB_C] = fc;
    nflag[FB_Z] = fz;
    nflag[FB_N] = fn;
    nflag[FB_V] = fv;
    nflag[FB_S] = fn ^ fv;
    nflag[FB_H] = fh;
  end

  // word first pass capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wsub_q <= 1'b0;
      c1_q   <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      busy_q <= accept && is_word;
      if (accept && is_word) begin
        wsub_q <= (op_e == OP_WSUB);
        c1_q   <= as_c;
        lo_q   <= as_r;
        hi_q   <= in_b;
      end
    end
  end

  // output slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q     <= 1'b0;
      res_q    <= '0;
      res_hi_q <= '0;
      wr_q     <= 1'b0;
      we_q     <= '0;
    end else if (load) begin
      ov_q     <= 1'b1;
      res_q    <= nres;
      res_hi_q <= nres_hi;
      wr_q     <= nwr;
      we_q     <= nmask;
    end else if (out_ready) begin
      ov_q     <= 1'b0;
    end
  end

  alu8_flagreg #(.FW(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd(load), .mask(nmask), .nxt(nflag), .q(flags_q)
  );

  assign out_valid   = ov_q;
  assign out_res     = res_q;
  assign out_res_hi  = res_hi_q;
  assign out_wr      = wr_q;
  assign out_flag_we = we_q;
  assign flags       = flags_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk import alu8_pkg::*; #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_res,
  input logic [DATA_W-1:0] out_res_hi,
  input logic [FLAG_W-1:0] out_flag_we,
  input logic [FLAG_W-1:0] flags
);
  logic acc_w, acc_b;
  assign acc_w = in_valid && in_ready && (in_op == OP_WADD || in_op == OP_WSUB);
  assign acc_b = in_valid && in_ready && !(in_op == OP_WADD || in_op == OP_WSUB);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_res_hi))
    else $error("stalled result moved"); // R13
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready)
    else $error("input accepted into full slot"); // R13
  AST_BYTE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_b |=> out_valid)
    else $error("byte result late"); // R13
  AST_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> !out_valid && !in_ready)
    else $error("word result early or input open"); // R11
  AST_WORD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |-> ##2 out_valid)
    else $error("word result missing"); // R11
  AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags ^ $past(flags)) & ~out_flag_we) == '0)
    else $error("flag outside mask changed"); // R14
  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_we[FB_S] |-> flags[FB_S] == (flags[FB_N] ^ flags[FB_V]))
    else $error("S differs from N^V"); // R12
  AST_QUIET_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_we == '0 |-> $stable(flags))
    else $error("flag moved on flagless op"); // R10
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
  .out_res_hi(out_res_hi), .out_flag_we(out_flag_we), .flags(flags)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
  import alu8_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0;
  logic [5:0] in_k = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_res, out_res_hi;
  logic out_wr;
  logic [5:0] out_flag_we, flags;

  always #2 clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_k(in_k), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_res_hi(out_res_hi), .out_wr(out_wr),
    .out_flag_we(out_flag_we), .flags(flags)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // flags written {H,S,V,N,Z,C}
  localparam logic [5:0] ALL = 6'b111111;
  localparam logic [5:0] LOG = 6'b011110;
  localparam logic [5:0] SHF = 6'b011111;
  localparam logic [5:0] NON = 6'b000000;

  typedef struct packed {
    alu_op_e    op;
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
    logic [7:0] res;
    logic [5:0] flg;
    logic [5:0] we;
    logic       wr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{OP_ADD,   8'h3A, 8'h26, 1'b0, 8'h60, 6'b100000, ALL, 1'b1},
    '{OP_ADD,   8'h80, 8'h80, 1'b0, 8'h00, 6'b011011, ALL, 1'b1},
    '{OP_ADC,   8'h7F, 8'h00, 1'b1, 8'h80, 6'b101100, ALL, 1'b1},
    '{OP_SUB,   8'h10, 8'h01, 1'b0, 8'h0F, 6'b100000, ALL, 1'b1},
    '{OP_SBC,   8'h00, 8'h00, 1'b1, 8'hFF, 6'b110101, ALL, 1'b1},
    '{OP_CMP,   8'h80, 8'h01, 1'b0, 8'h7F, 6'b111000, ALL, 1'b0},
    '{OP_CPC,   8'h05, 8'h05, 1'b1, 8'hFF, 6'b110101, ALL, 1'b0},
    '{OP_AND,   8'hF0, 8'h3C, 1'b1, 8'h30, 6'b100001, LOG, 1'b1},
    '{OP_OR,    8'h00, 8'h00, 1'b1, 8'h00, 6'b100011, LOG, 1'b1},
    '{OP_XOR,   8'hA5, 8'h0F, 1'b0, 8'hAA, 6'b010100, LOG, 1'b1},
    '{OP_COM,   8'h55, 8'h00, 1'b0, 8'hAA, 6'b010101, SHF, 1'b1},
    '{OP_NEG,   8'h01, 8'h00, 1'b0, 8'hFF, 6'b110101, ALL, 1'b1},
    '{OP_NEG,   8'h80, 8'h00, 1'b0, 8'h80, 6'b001101, ALL, 1'b1},
    '{OP_INC,   8'h7F, 8'h00, 1'b1, 8'h80, 6'b101101, LOG, 1'b1},
    '{OP_DEC,   8'h80, 8'h00, 1'b0, 8'h7F, 6'b011000, LOG, 1'b1},
    '{OP_DEC,   8'h01, 8'h00, 1'b1, 8'h00, 6'b100011, LOG, 1'b1},
    '{OP_SHL,   8'h81, 8'h00, 1'b0, 8'h02, 6'b011001, SHF, 1'b1},
    '{OP_SHR,   8'h01, 8'h00, 1'b1, 8'h00, 6'b111011, SHF, 1'b1},
    '{OP_SAR,   8'h81, 8'h00, 1'b0, 8'hC0, 6'b010101, SHF, 1'b1},
    '{OP_RCL,   8'h80, 8'h00, 1'b1, 8'h01, 6'b111001, SHF, 1'b1},
    '{OP_RCR,   8'h02, 8'h00, 1'b1, 8'h81, 6'b101100, SHF, 1'b1},
    '{OP_RCL,   8'h40, 8'h00, 1'b0, 8'h80, 6'b001100, SHF, 1'b1},
    '{OP_NSWAP, 8'h3C, 8'h00, 1'b1, 8'hC3, 6'b110101, NON, 1'b1},
    '{OP_ONES,  8'h12, 8'h00, 1'b0, 8'hFF, 6'b000000, NON, 1'b1}
  };

  function automatic string req_of(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC:                 return "R2";
      OP_SUB, OP_SBC, OP_NEG:         return "R3";
      OP_CMP, OP_CPC:                 return "R4";
      OP_AND, OP_OR, OP_XOR:          return "R5";
      OP_COM:                         return "R6";
      OP_INC, OP_DEC:                 return "R7";
      OP_SHL, OP_SHR, OP_SAR:         return "R8";
      OP_RCL, OP_RCR:                 return "R9";
      OP_NSWAP, OP_ONES:              return "R10";
      default:                        return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input alu_op_e op, input logic [7:0] a, input logic [7:0] b,
                       input logic [5:0] k, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_k = k;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // flags 000000 when c is 0, 110101 when c is 1
  task automatic prep(input logic c);
    int lat;
    if (c) do_op(OP_SUB, 8'h00, 8'h01, 6'd0, lat);
    else   do_op(OP_ADD, 8'h01, 8'h01, 6'd0, lat);
  endtask

  task automatic word_case(input alu_op_e op, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [5:0] k, input logic c, input logic [15:0] exp_r,
                           input logic [5:0] exp_f);
    int lat;
    prep(c);
    do_op(op, lo, hi, k, lat);
    chk("R11", "word latency", lat, 2);
    chk("R11", "word result", {out_res_hi, out_res}, exp_r);
    chk("R11", "word flags", flags, exp_f);
    chk("R11", "word mask", out_flag_we, SHF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R13 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "flags", flags, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flags after release", flags, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      prep(TBL[i].cin);
      do_op(TBL[i].op, TBL[i].a, TBL[i].b, 6'd0, lat);
      chk(req_of(TBL[i].op), "result", out_res, TBL[i].res);
      chk(req_of(TBL[i].op), "flags", flags, TBL[i].flg);
      chk(req_of(TBL[i].op), "mask", out_flag_we, TBL[i].we);
      chk(req_of(TBL[i].op), "wr", out_wr, TBL[i].wr);
      chk("R13", "byte latency", lat, 1);
      if (TBL[i].we[4]) chk("R12", "S=N^V", flags[4], flags[2] ^ flags[3]);
    end

    // R11 word operations
    word_case(OP_WADD, 8'hFF, 8'h00, 6'd1, 1'b1, 16'h0100, 6'b100000);
    word_case(OP_WADD, 8'hFF, 8'hFF, 6'd1, 1'b0, 16'h0000, 6'b000011);
    word_case(OP_WADD, 8'hFF, 8'h7F, 6'd1, 1'b0, 16'h8000, 6'b001100);
    word_case(OP_WSUB, 8'h00, 8'h00, 6'd1, 1'b0, 16'hFFFF, 6'b010101);
    word_case(OP_WSUB, 8'h00, 8'h80, 6'd63, 1'b1, 16'h7FC1, 6'b111000);

    // R3 carry written on one edge, read by the next operation back to back
    @(negedge clk);
    in_valid = 1'b1; in_op = OP_SUB; in_a = 8'h00; in_b = 8'h01;
    @(negedge clk);
    in_op = OP_ADC; in_a = 8'h00; in_b = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "back-to-back adc", out_res, 8'h01);

    // R13 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    do_op(OP_ADD, 8'h10, 8'h20, 6'd0, lat);
    in_valid = 1'b1; in_op = OP_ADD; in_a = 8'h01; in_b = 8'h01;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R13", "held valid", out_valid, 1);
      chk("R13", "held ready low", in_ready, 0);
      chk("R13", "held result", out_res, 8'h30);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R13", "drain and accept", out_res, 8'h02);
    chk("R13", "new valid", out_valid, 1);
    @(negedge clk);
    chk("R13", "slot empty", out_valid, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule